// File: doc/BRIEF.md
# Matrix Keypad Scan Register Controller

This block is the register side of a keypad controller for a matrix of up to eight rows by eight columns. A host reads and writes ten 32-bit registers over a simple single-cycle bus. A scanning front end delivers key events that are already decoded into a row, a column and a press/release flag. The block records pressed keys in four multi-key registers, one for each pair of columns. It also holds a control word, a direct-key word, a rotary status word, a matrix-key word, a scan-status word and a debounce-interval word. Some status flags clear when their register is read.

An event counts only when the control word enables the matrix and requests scanning. When it counts, it may raise a level interrupt. The host reads the control word to acknowledge that interrupt. Accesses to offsets that hold no register read as zero, change nothing, and report an error for one cycle.

Top module: `keymat_ctrl`

## Requirements
- R1: A bus write loads all 32 bits into the register at that byte offset, and a later read returns the value. The offsets are: control 0x00, direct key 0x08, rotary 0x10, matrix key 0x18, scan status 0x20, multi-key 0 to 3 at 0x28, 0x30, 0x38, 0x40, and debounce 0x48. Read data is combinational in the cycle of the read. A write is visible from the next cycle.
- R2: A key event is ignored unless control bit 12 (matrix enable) is set and at least one of control bit 30 (one-shot scan) or bit 29 (scan on activity) is set.
- R3: An accepted event clears control bit 30. Control bit 29 keeps its value.
- R4: An accepted press sets bit (row + 16·(col mod 2)) in multi-key register col/2. Every other bit keeps its value.
- R5: An accepted release clears the whole multi-key register col/2 to zero, whatever row it names.
- R6: When control bit 11 (matrix interrupt enable) is set, an accepted event sets control bit 22 and drives `irq` high from the next cycle. When bit 11 is clear, neither changes.
- R7: A read of the control word returns its value from before the read. It then clears control bits 22 and 5 and drives `irq` low. An event accepted in the same cycle still raises the interrupt.
- R8: A read of the rotary word clears its bits 31, 30, 15 and 14. A read of the matrix-key word clears its bit 31. All other bits keep their values.
- R9: If a bus write and an accepted event target the same register in the same cycle, the written value is what gets stored.
- R10: A read or write at an offset that holds no register reads as zero and changes no register. It drives `bus_err` high for exactly the next cycle.
- R11: An event whose row or column is 8 or more is dropped and changes no state.
- R12: After reset every register reads zero and `irq` and `bus_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle pulse after an access to an undefined offset |
| ev_valid | input | 1 | Key event strobe |
| ev_row | input | 4 | Event row |
| ev_col | input | 4 | Event column |
| ev_release | input | 1 | 1 = release, 0 = press |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the cases where the event path and the bus path meet. One is a write and an event aimed at the same multi-key register in the same cycle; a design that let the event win would keep a stale bit. Another is a release on a row that was never pressed; a design that cleared only one bit would leave the other keys set. The bench also checks that the one-shot scan bit clears after one accepted event while scan on activity stays set, that a control read returns the flags before clearing them, and that events with row or column 8 or 9 leave every register alone. A design that wrapped those coordinates into range would corrupt a neighbouring key.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NREG   = 10;
  localparam int unsigned NMK    = 4;
  // register index = byte offset / 8
  localparam int unsigned IX_CTRL = 0;
  localparam int unsigned IX_DK   = 1;
  localparam int unsigned IX_ROT  = 2;
  localparam int unsigned IX_MKEY = 3;
  localparam int unsigned IX_SCAN = 4;
  localparam int unsigned IX_MK0  = 5;
  localparam int unsigned IX_DBI  = 9;
  // control word bit positions
  localparam int unsigned CB_ONESHOT = 30;
  localparam int unsigned CB_ACTIV   = 29;
  localparam int unsigned CB_MFLAG   = 22;
  localparam int unsigned CB_MEN     = 12;
  localparam int unsigned CB_MIE     = 11;
  localparam int unsigned CB_DFLAG   = 5;
  // read-to-clear masks
  localparam logic [DW-1:0] ROT_RC_MASK  = 32'hC000_C000;
  localparam logic [DW-1:0] MKEY_RC_MASK = 32'h8000_0000;
endpackage

// File: rtl/keymat_decode.sv
module keymat_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NREG   = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel,
  output logic              hit
);
  localparam int unsigned IX_W = ADDR_W - 3;

  logic [IX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:3];
  assign hit = (addr[2:0] == 3'b000) && (int'(idx) < NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = hit && (idx == IX_W'(i));
  end
endmodule

// File: rtl/keymat_event.sv
module keymat_event #(
  parameter int unsigned COORD_W = 4,
  parameter int unsigned ROWS    = 8,
  parameter int unsigned COLS    = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned NMK     = 4
) (
  input  logic               ev_valid,
  input  logic [COORD_W-1:0] ev_row,
  input  logic [COORD_W-1:0] ev_col,
  input  logic               mat_en,
  input  logic               scan_req,
  output logic               acc,
  output logic [NMK-1:0]     mk_hit,
  output logic [DW-1:0]      set_mask
);
  localparam int unsigned HALF = DW / 2;

  logic in_range;
  int unsigned shamt;

  assign in_range = (int'(ev_row) < ROWS) && (int'(ev_col) < COLS);
  assign acc      = ev_valid && in_range && mat_en && scan_req;

  always_comb begin
    shamt    = int'(ev_row) + (ev_col[0] ? HALF : 0);
    set_mask = {{(DW-1){1'b0}}, 1'b1} << shamt;
  end

  for (genvar i = 0; i < NMK; i++) begin : g_hit
    assign mk_hit[i] = acc && (ev_col[COORD_W-1:1] == (COORD_W-1)'(i));
  end
endmodule

// File: rtl/keymat_mkbank.sv
module keymat_mkbank #(
  parameter int unsigned NMK = 4,
  parameter int unsigned DW  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NMK-1:0]         mk_hit,
  input  logic                   release_ev,
  input  logic [DW-1:0]          set_mask,
  input  logic [NMK-1:0]         wr_sel,
  input  logic [DW-1:0]          wdata,
  output logic [NMK-1:0][DW-1:0] q
);
  for (genvar i = 0; i < NMK; i++) begin : g_reg
    logic [DW-1:0] d;
    logic          en;

    assign en = mk_hit[i] || wr_sel[i];

    always_comb begin
      d = q[i];
      if (mk_hit[i]) d = release_ev ? '0 : (q[i] | set_mask);
      if (wr_sel[i]) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= '0;
      else if (en) q[i] <= d;
    end
  end
endmodule

// File: rtl/keymat_ctrl.sv
module keymat_ctrl
  import keymat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned COORD_W = 4,
  parameter int unsigned ROWS    = 8,
  parameter int unsigned COLS    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_err,
  input  logic               ev_valid,
  input  logic [COORD_W-1:0] ev_row,
  input  logic [COORD_W-1:0] ev_col,
  input  logic               ev_release,
  output logic               irq
);
  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NREG-1:0] sel, wr_sel, rd_sel;
  logic            hit;

  keymat_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(bus_addr), .sel(sel), .hit(hit)
  );
  assign wr_sel = sel & {NREG{bus_wr}};
  assign rd_sel = sel & {NREG{bus_rd}};

  logic [DW-1:0] ctrl_q, ctrl_d, dk_q, rot_q, rot_d, mkey_q, mkey_d, scan_q, dbi_q;
  logic          irq_d, err_d;
  logic          ev_acc;
  logic [NMK-1:0]         mk_hit;
  logic [DW-1:0]          set_mask;
  logic [NMK-1:0][DW-1:0] mk_q;

  keymat_event #(.COORD_W(COORD_W), .ROWS(ROWS), .COLS(COLS), .DW(DW), .NMK(NMK)) u_ev (
    .ev_valid(ev_valid), .ev_row(ev_row), .ev_col(ev_col),
    .mat_en(ctrl_q[CB_MEN]),
    .scan_req(ctrl_q[CB_ONESHOT] | ctrl_q[CB_ACTIV]),
    .acc(ev_acc), .mk_hit(mk_hit), .set_mask(set_mask)
  );

  keymat_mkbank #(.NMK(NMK), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .mk_hit(mk_hit), .release_ev(ev_release),
    .set_mask(set_mask), .wr_sel(wr_sel[IX_MK0 +: NMK]), .wdata(bus_wdata), .q(mk_q)
  );

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    if (rd_sel[IX_CTRL]) begin
      ctrl_d[CB_MFLAG] = 1'b0;
      ctrl_d[CB_DFLAG] = 1'b0;
    end
    if (ev_acc) begin
      ctrl_d[CB_ONESHOT] = 1'b0;
      if (ctrl_q[CB_MIE]) ctrl_d[CB_MFLAG] = 1'b1;
    end
    if (wr_sel[IX_CTRL]) ctrl_d = bus_wdata;

    rot_d = rot_q;
    if (rd_sel[IX_ROT]) rot_d = rot_q & ~ROT_RC_MASK;
    if (wr_sel[IX_ROT]) rot_d = bus_wdata;

    mkey_d = mkey_q;
    if (rd_sel[IX_MKEY]) mkey_d = mkey_q & ~MKEY_RC_MASK;
    if (wr_sel[IX_MKEY]) mkey_d = bus_wdata;

    irq_d = irq;
    if (rd_sel[IX_CTRL])          irq_d = 1'b0;
    if (ev_acc && ctrl_q[CB_MIE]) irq_d = 1'b1;

    err_d = (bus_rd || bus_wr) && !hit;
  end

  // registers with explicit enables
  logic ctrl_en, rot_en, mkey_en;
  assign ctrl_en = rd_sel[IX_CTRL] || ev_acc || wr_sel[IX_CTRL];
  assign rot_en  = rd_sel[IX_ROT]  || wr_sel[IX_ROT];
  assign mkey_en = rd_sel[IX_MKEY] || wr_sel[IX_MKEY];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      dk_q    <= '0;
      rot_q   <= '0;
      mkey_q  <= '0;
      scan_q  <= '0;
      dbi_q   <= '0;
      irq     <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      if (ctrl_en)          ctrl_q <= ctrl_d;
      if (wr_sel[IX_DK])    dk_q   <= bus_wdata;
      if (rot_en)           rot_q  <= rot_d;
      if (mkey_en)          mkey_q <= mkey_d;
      if (wr_sel[IX_SCAN])  scan_q <= bus_wdata;
      if (wr_sel[IX_DBI])   dbi_q  <= bus_wdata;
      irq     <= irq_d;
      bus_err <= err_d;
    end
  end

  // read mux
  logic [NREG-1:0][DW-1:0] rd_vec;
  always_comb begin
    rd_vec          = '0;
    rd_vec[IX_CTRL] = ctrl_q;
    rd_vec[IX_DK]   = dk_q;
    rd_vec[IX_ROT]  = rot_q;
    rd_vec[IX_MKEY] = mkey_q;
    rd_vec[IX_SCAN] = scan_q;
    rd_vec[IX_DBI]  = dbi_q;
    for (int i = 0; i < NMK; i++) rd_vec[IX_MK0 + i] = mk_q[i];
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++) if (sel[i]) bus_rdata = bus_rdata | rd_vec[i];
  end
endmodule

// File: rtl/keymat_ctrl_chk.sv
module keymat_ctrl_chk
  import keymat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned COORD_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_rd,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DW-1:0]          bus_rdata,
  input logic                   bus_err,
  input logic                   irq,
  input logic                   ev_valid,
  input logic                   ev_release,
  input logic [COORD_W-1:0]     ev_row,
  input logic [COORD_W-1:0]     ev_col,
  input logic                   ev_acc,
  input logic                   hit,
  input logic [NREG-1:0]        wr_sel,
  input logic [DW-1:0]          ctrl_q,
  input logic [NMK-1:0][DW-1:0] mk_q
);
  p_ignore_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ctrl_q[CB_MEN] && !bus_wr) |=> $stable(mk_q));

  p_oneshot_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc && !wr_sel[IX_CTRL]) |=> !ctrl_q[CB_ONESHOT]);

  p_release_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc && ev_release && !bus_wr) |=> (mk_q[$past(ev_col[2:1])] == '0));

  p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc && ctrl_q[CB_MIE] && !bus_wr) |=> (irq && ctrl_q[CB_MFLAG]));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_acc));

  p_ctrl_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && bus_addr == '0 && !ev_acc) |=> !irq);

  p_drop_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && (ev_row[COORD_W-1] || ev_col[COORD_W-1]) && !bus_wr) |=> $stable(mk_q));

  p_bad_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !hit) |=> bus_err);

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past((bus_rd || bus_wr) && !hit));

  p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |-> (bus_rdata == '0));
endmodule

bind keymat_ctrl keymat_ctrl_chk #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq), .ev_valid(ev_valid),
  .ev_release(ev_release), .ev_row(ev_row), .ev_col(ev_col), .ev_acc(ev_acc),
  .hit(hit), .wr_sel(wr_sel), .ctrl_q(ctrl_q), .mk_q(mk_q)
);

// File: tb/keymat_ctrl_bench.sv
`timescale 1ns/1ps
module keymat_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, bus_err, ev_valid, ev_release, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  ev_row, ev_col;

  always #2.5 clk = ~clk;

  keymat_ctrl u_keymat_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ev_valid(ev_valid), .ev_row(ev_row), .ev_col(ev_col), .ev_release(ev_release),
    .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m [10];
  bit m_irq;

  function automatic bit is_hit(input logic [7:0] a);
    return (a[2:0] == 3'b000) && ((a >> 3) < 10);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    return is_hit(a) ? m[a >> 3] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of one cycle, from the requirements
  task automatic model_edge(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d,
                            input bit ev, input logic [3:0] row, input logic [3:0] col,
                            input bit rel);
    logic [31:0] c;
    int ix;
    bit acc;
    c   = m[0];
    acc = ev && row < 8 && col < 8 && c[12] && (c[30] || c[29]);
    if (rd && is_hit(a)) begin
      ix = int'(a >> 3);
      if (ix == 0) begin m[0][22] = 1'b0; m[0][5] = 1'b0; m_irq = 1'b0; end
      if (ix == 2) m[2] = m[2] & 32'h3FFF_3FFF;
      if (ix == 3) m[3] = m[3] & 32'h7FFF_FFFF;
    end
    if (acc) begin
      m[0][30] = 1'b0;
      if (c[11]) begin m[0][22] = 1'b1; m_irq = 1'b1; end
      ix = 5 + int'(col) / 2;
      if (rel) m[ix] = 32'h0;
      else     m[ix][int'(row) + 16 * (int'(col) % 2)] = 1'b1;
    end
    if (wr && is_hit(a)) m[a >> 3] = d;
  endtask

  task automatic step(input string tag, input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] d, input bit ev, input logic [3:0] row,
                      input logic [3:0] col, input bit rel);
    bit bad;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    ev_valid = ev; ev_row = row; ev_col = col; ev_release = rel;
    #1;
    if (rd) check({tag, " rdata"}, bus_rdata, exp_read(a));
    bad = (wr || rd) && !is_hit(a);
    @(posedge clk);
    model_edge(wr, rd, a, d, ev, row, col, rel);
    #1;
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    check({tag, " err"}, {31'b0, bus_err}, {31'b0, bad});
  endtask

  task automatic wr_reg(input string tag, input logic [7:0] a, input logic [31:0] d);
    step(tag, 1, 0, a, d, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(input string tag, input logic [7:0] a);
    step(tag, 0, 1, a, 0, 0, 0, 0, 0);
  endtask
  task automatic key(input string tag, input int row, input int col, input bit rel);
    step(tag, 0, 0, 8'h00, 0, 1, 4'(row), 4'(col), rel);
  endtask

  localparam logic [31:0] MEN = 32'h1 << 12, MIE = 32'h1 << 11;
  localparam logic [31:0] ONE = 32'h1 << 30, ACT = 32'h1 << 29, DFL = 32'h1 << 5;

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 10; i++) m[i] = 32'h0;
    m_irq = 0;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ev_valid = 0; ev_row = 0; ev_col = 0; ev_release = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R12 reset state
    for (int i = 0; i < 10; i++) rd_reg("R12", 8'(i * 8));

    // R1 write and read back every register
    for (int i = 0; i < 10; i++) wr_reg("R1", 8'(i * 8), 32'h1111_0000 * (i + 1) + 32'(i));
    for (int i = 1; i < 10; i++) rd_reg("R1", 8'(i * 8));
    wr_reg("R1", 8'h00, 32'h0);

    // R8 read-to-clear on rotary and matrix-key words
    wr_reg("R8", 8'h10, 32'hFFFF_FFFF);
    rd_reg("R8", 8'h10); rd_reg("R8", 8'h10);
    wr_reg("R8", 8'h18, 32'hFFFF_FFFF);
    rd_reg("R8", 8'h18); rd_reg("R8", 8'h18);

    for (int i = 5; i < 9; i++) wr_reg("R1", 8'(i * 8), 32'h0);

    // R2 events ignored without enable or without scan request
    wr_reg("R2", 8'h00, MEN | MIE);
    key("R2", 2, 3, 0); rd_reg("R2", 8'h30);
    wr_reg("R2", 8'h00, ONE | ACT | MIE);
    key("R2", 2, 3, 0); rd_reg("R2", 8'h30);

    // R3 R4 R6 R7 one-shot press with interrupt
    wr_reg("R3", 8'h00, MEN | ONE | MIE);
    key("R6", 2, 3, 0);
    rd_reg("R4", 8'h30);
    rd_reg("R7", 8'h00);
    rd_reg("R3", 8'h00);
    key("R3", 1, 3, 0); rd_reg("R3", 8'h30);

    // R7 direct flag also clears on control read
    wr_reg("R7", 8'h00, MEN | ACT | DFL);
    rd_reg("R7", 8'h00); rd_reg("R7", 8'h00);

    // R4 R5 scan-on-activity presses and a release on an unpressed row
    key("R4", 7, 7, 0); key("R4", 0, 6, 0); key("R4", 5, 4, 0);
    rd_reg("R4", 8'h40); rd_reg("R4", 8'h38); rd_reg("R4", 8'h00);
    key("R5", 3, 6, 1);
    rd_reg("R5", 8'h40); rd_reg("R5", 8'h30); rd_reg("R5", 8'h38);

    // R9 write and event on the same register; then on different registers
    step("R9", 1, 0, 8'h28, 32'hA5A5_0000, 1, 4'd1, 4'd0, 0);
    rd_reg("R9", 8'h28);
    step("R9", 1, 0, 8'h28, 32'h0000_0F00, 1, 4'd6, 4'd5, 0);
    rd_reg("R9", 8'h28); rd_reg("R9", 8'h38);

    // R11 out-of-range coordinates, with interrupt enabled
    wr_reg("R11", 8'h00, MEN | ACT | MIE);
    key("R11", 8, 0, 0); key("R11", 0, 9, 0); key("R11", 9, 8, 1);
    for (int i = 5; i < 9; i++) rd_reg("R11", 8'(i * 8));
    rd_reg("R11", 8'h00);

    // R10 undefined offsets
    rd_reg("R10", 8'h50); rd_reg("R10", 8'h04); rd_reg("R10", 8'hF8);
    wr_reg("R10", 8'h2C, 32'hDEAD_BEEF); wr_reg("R10", 8'h58, 32'hDEAD_BEEF);
    for (int i = 0; i < 10; i++) rd_reg("R10", 8'(i * 8));

    // mixed random traffic checked against the model
    for (int n = 0; n < 600; n++) begin
      int kind = int'($urandom_range(0, 9));
      logic [7:0] a = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(0, 255))
                                                   : 8'($urandom_range(0, 9) * 8);
      logic [31:0] d = $urandom;
      if (kind == 0) begin
        d = ($urandom_range(0, 3) == 0) ? $urandom
          : (MEN | (32'($urandom_range(0, 7)) << 29) & (ONE | ACT)) | MIE | ($urandom & 32'h0040_0020);
        step("R1 mix", 1, 0, 8'h00, d, 0, 0, 0, 0);
      end else if (kind == 1) begin
        step("R1 mix", 1, 0, a, d, 0, 0, 0, 0);
      end else if (kind <= 4) begin
        step("R8 mix", 0, 1, a, 0, 0, 0, 0, 0);
      end else begin
        step("R4 mix", 0, 0, 8'h00, 0, 1, 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
             $urandom_range(0, 5) == 0);
      end
    end
    for (int i = 0; i < 10; i++) rd_reg("R1 final", 8'(i * 8));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule